// File: doc/BRIEF.md
# Strided Pointer Data Memory

This block is a data-memory front end for a move-based processor. It holds a 256-word, 8-bit memory that software never addresses directly. Instead there are two independent channels, each with a pointer register, a stride-exponent register and a data port. Software loads a pointer, then moves words to or from that channel's data port. Each such transfer uses the pointer's current value as the memory address, then advances the pointer by two to the power of the channel's stride exponent. Addresses wrap within the 256-word space.

Both channels reach the array in the same cycle through its two ports. This lets a copy loop or a two-stream computation move data without pointer arithmetic in the instruction stream. The pointer and stride registers are visible as outputs, so the surrounding bus can read them back. The decoder that turns bus addresses into the per-channel load, read and write strobes lives outside this block.

Top module: `ptr_ram_unit`

## Requirements
- R1: After synchronous reset, both pointers read 0, both stride exponents read 0, and both read-valid outputs are 0.
- R2: A pointer-load strobe makes that channel's pointer output equal the loaded value from the next cycle on.
- R3: A stride-load strobe makes that channel's stride output equal the loaded 3-bit exponent from the next cycle on.
- R4: A read strobe on a channel makes its read-valid output 1 in the next cycle, with read data equal to the word at the pointer value held before the access. Without a read strobe, read-valid is 0 in the next cycle.
- R5: A write strobe stores the write data at the pointer value held before the access.
- R6: A read or write on a channel, or both together as a single access, advances its pointer by 2^k modulo 256. Here k is the stride exponent held before that cycle, even if the stride is loaded in the same cycle.
- R7: When a pointer load and an access on the same channel fall in one cycle, the access uses the old pointer, and the pointer takes the loaded value with no increment.
- R8: The two channels work independently in the same cycle, each with its own pointer, stride and data.
- R9: When both channels write the same address in one cycle, the word written by channel 0 is kept.
- R10: A read of an address that is written in the same cycle, through either channel, returns the contents from before the write.
- R11: With no load and no access, a channel's pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ptr_ld_i | input | 2 | Per-channel pointer load strobe (bit 0 = channel 0) |
| ptr_val_i | input | 2*ADDR_W | Pointer load values, channel 0 in the low field |
| stride_ld_i | input | 2 | Per-channel stride exponent load strobe |
| stride_val_i | input | 2*SHIFT_W | Stride exponents to load, channel 0 in the low field |
| rd_i | input | 2 | Per-channel read strobe on the data port |
| wr_i | input | 2 | Per-channel write strobe on the data port |
| wdata_i | input | 2*DATA_W | Write data, channel 0 in the low field |
| rdata_o | output | 2*DATA_W | Registered read data, channel 0 in the low field |
| rvalid_o | output | 2 | Read data valid, one cycle after a read strobe |
| ptr_o | output | 2*ADDR_W | Current pointer values |
| stride_o | output | 2*SHIFT_W | Current stride exponents |

## Verification
The bench builds the block with its defaults: 8-bit addresses, so 256 words and stride exponents 0 to 7, and 8-bit data. With these values the largest stride of 128 can wrap the pointer past the top of the array in a single step. All pointer values can be written and checked literally. Each channel's read results pass through a scoreboard fed by a reference model of the pointers and memory. The same-cycle cases (load against access, write against write, read against write) are driven on purpose and compared against that model.

// File: rtl/ptr_ram_pkg.sv
package ptr_ram_pkg;
  parameter int unsigned PR_ADDR_W = 8;
  parameter int unsigned PR_DATA_W = 8;
  parameter int unsigned PR_NCHAN  = 2;
endpackage

// File: rtl/ptr_ram_ptr.sv
module ptr_ram_ptr #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               ld_i,
  input  logic [ADDR_W-1:0]  ld_val_i,
  input  logic               st_ld_i,
  input  logic [SHIFT_W-1:0] st_val_i,
  input  logic               acc_i,
  output logic [ADDR_W-1:0]  ptr_q,
  output logic [SHIFT_W-1:0] stride_q
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] ptr_nxt;

  // one-hot step from the stride currently held
  always_comb begin
    step = '0;
    step[stride_q] = 1'b1;
  end

  always_comb begin
    if (ld_i)       ptr_nxt = ld_val_i;
    else if (acc_i) ptr_nxt = ptr_q + step;
    else            ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q    <= '0;
      stride_q <= '0;
    end else begin
      ptr_q <= ptr_nxt;
      if (st_ld_i) stride_q <= st_val_i;
    end
  end
endmodule

// File: rtl/ptr_ram_array.sv
module ptr_ram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              re_a_i,
  input  logic              we_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wd_a_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic              re_b_i,
  input  logic              we_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first registered reads
  always_ff @(posedge clk_i) begin
    if (re_a_i) rd_a_o <= mem[addr_a_i];
    if (re_b_i) rd_b_o <= mem[addr_b_i];
  end

  // port a is written last so it wins a shared address
  always_ff @(posedge clk_i) begin
    if (we_b_i) mem[addr_b_i] <= wd_b_i;
    if (we_a_i) mem[addr_a_i] <= wd_a_i;
  end
endmodule

// File: rtl/ptr_ram_unit.sv
module ptr_ram_unit
  import ptr_ram_pkg::*;
#(
  parameter int unsigned ADDR_W = PR_ADDR_W,
  parameter int unsigned DATA_W = PR_DATA_W,
  localparam int unsigned SHIFT_W = $clog2(ADDR_W),
  localparam int unsigned NCH = PR_NCHAN
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [NCH-1:0]         ptr_ld_i,
  input  logic [NCH*ADDR_W-1:0]  ptr_val_i,
  input  logic [NCH-1:0]         stride_ld_i,
  input  logic [NCH*SHIFT_W-1:0] stride_val_i,
  input  logic [NCH-1:0]         rd_i,
  input  logic [NCH-1:0]         wr_i,
  input  logic [NCH*DATA_W-1:0]  wdata_i,
  output logic [NCH*DATA_W-1:0]  rdata_o,
  output logic [NCH-1:0]         rvalid_o,
  output logic [NCH*ADDR_W-1:0]  ptr_o,
  output logic [NCH*SHIFT_W-1:0] stride_o
);
  logic [NCH-1:0] acc;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign acc[c] = rd_i[c] | wr_i[c];
    ptr_ram_ptr #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_ptr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ld_i    (ptr_ld_i[c]),
      .ld_val_i(ptr_val_i[c*ADDR_W +: ADDR_W]),
      .st_ld_i (stride_ld_i[c]),
      .st_val_i(stride_val_i[c*SHIFT_W +: SHIFT_W]),
      .acc_i   (acc[c]),
      .ptr_q   (ptr_o[c*ADDR_W +: ADDR_W]),
      .stride_q(stride_o[c*SHIFT_W +: SHIFT_W])
    );
  end

  ptr_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .re_a_i  (rd_i[0]),
    .we_a_i  (wr_i[0]),
    .addr_a_i(ptr_o[0 +: ADDR_W]),
    .wd_a_i  (wdata_i[0 +: DATA_W]),
    .rd_a_o  (rdata_o[0 +: DATA_W]),
    .re_b_i  (rd_i[1]),
    .we_b_i  (wr_i[1]),
    .addr_b_i(ptr_o[ADDR_W +: ADDR_W]),
    .wd_b_i  (wdata_i[DATA_W +: DATA_W]),
    .rd_b_o  (rdata_o[DATA_W +: DATA_W])
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) rvalid_o <= '0;
    else       rvalid_o <= rd_i;
  end
endmodule

// File: rtl/ptr_ram_chk.sv
module ptr_ram_chk
  import ptr_ram_pkg::*;
#(
  parameter int unsigned ADDR_W = PR_ADDR_W,
  parameter int unsigned DATA_W = PR_DATA_W,
  localparam int unsigned SHIFT_W = $clog2(ADDR_W),
  localparam int unsigned NCH = PR_NCHAN
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic [NCH-1:0]         ptr_ld_i,
  input logic [NCH*ADDR_W-1:0]  ptr_val_i,
  input logic [NCH-1:0]         stride_ld_i,
  input logic [NCH*SHIFT_W-1:0] stride_val_i,
  input logic [NCH-1:0]         rd_i,
  input logic [NCH-1:0]         wr_i,
  input logic [NCH*DATA_W-1:0]  wdata_i,
  input logic [NCH*DATA_W-1:0]  rdata_o,
  input logic [NCH-1:0]         rvalid_o,
  input logic [NCH*ADDR_W-1:0]  ptr_o,
  input logic [NCH*SHIFT_W-1:0] stride_o
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk_i) rst_seen <= rst_i;

  // R1: one cycle after a reset edge everything is cleared
  always_ff @(posedge clk_i) begin
    if (rst_seen && !rst_i)
      a_r1_reset_state: assert (ptr_o == '0 && stride_o == '0 && rvalid_o == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ach
    a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (rst_i)
      ptr_ld_i[c] |=> ptr_o[c*ADDR_W +: ADDR_W] == $past(ptr_val_i[c*ADDR_W +: ADDR_W]));
    a_r3_stride_load: assert property (@(posedge clk_i) disable iff (rst_i)
      stride_ld_i[c] |=> stride_o[c*SHIFT_W +: SHIFT_W] == $past(stride_val_i[c*SHIFT_W +: SHIFT_W]));
    a_r4_rvalid_set: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_i[c] |=> rvalid_o[c]);
    a_r4_rvalid_clr: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd_i[c] |=> !rvalid_o[c]);
    a_r6_advance: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ptr_ld_i[c] && (rd_i[c] || wr_i[c])) |=>
      ptr_o[c*ADDR_W +: ADDR_W] == ADDR_W'($past(ptr_o[c*ADDR_W +: ADDR_W])
        + (ADDR_W'(1) << $past(stride_o[c*SHIFT_W +: SHIFT_W]))));
    a_r7_load_wins: assert property (@(posedge clk_i) disable iff (rst_i)
      (ptr_ld_i[c] && (rd_i[c] || wr_i[c])) |=>
      ptr_o[c*ADDR_W +: ADDR_W] == $past(ptr_val_i[c*ADDR_W +: ADDR_W]));
    a_r11_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ptr_ld_i[c] && !rd_i[c] && !wr_i[c]) |=> $stable(ptr_o[c*ADDR_W +: ADDR_W]));
  end
endmodule

bind ptr_ram_unit ptr_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ptr_ram_unit_tb.sv
module ptr_ram_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]  ptr_ld = '0, stride_ld = '0, rd = '0, wr = '0;
  logic [15:0] ptr_val = '0, wdata = '0;
  logic [5:0]  stride_val = '0;
  logic [15:0] rdata, ptr;
  logic [1:0]  rvalid;
  logic [5:0]  stride;

  ptr_ram_unit u_dut (
    .clk_i(clk), .rst_i(rst), .ptr_ld_i(ptr_ld), .ptr_val_i(ptr_val),
    .stride_ld_i(stride_ld), .stride_val_i(stride_val), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .ptr_o(ptr), .stride_o(stride)
  );

  int checks = 0, fails = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_ptr [2];
  logic [2:0] m_st [2];
  logic [7:0] q0 [$];
  logic [7:0] q1 [$];
  string t0 [$];
  string t1 [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (!rst) begin
      if (rvalid[0]) begin
        if (q0.size() == 0) chk("R4", 1, 0);
        else chk(t0.pop_front(), int'(rdata[7:0]), int'(q0.pop_front()));
      end
      if (rvalid[1]) begin
        if (q1.size() == 0) chk("R4", 1, 0);
        else chk(t1.pop_front(), int'(rdata[15:8]), int'(q1.pop_front()));
      end
    end
  end

  task automatic set_ptr(int c, logic [7:0] v);
    ptr_ld[c] = 1'b1; ptr_val[c*8 +: 8] = v;
  endtask
  task automatic set_st(int c, logic [2:0] k);
    stride_ld[c] = 1'b1; stride_val[c*3 +: 3] = k;
  endtask
  task automatic do_wr(int c, logic [7:0] d);
    wr[c] = 1'b1; wdata[c*8 +: 8] = d;
  endtask
  task automatic do_rd(int c);
    rd[c] = 1'b1;
  endtask

  // driver: model the cycle, push expected reads, advance one clock
  task automatic step(string tag);
    if (rd[0]) begin q0.push_back(m_mem[m_ptr[0]]); t0.push_back(tag); end
    if (rd[1]) begin q1.push_back(m_mem[m_ptr[1]]); t1.push_back(tag); end
    if (wr[1]) m_mem[m_ptr[1]] = wdata[15:8];
    if (wr[0]) m_mem[m_ptr[0]] = wdata[7:0];
    for (int c = 0; c < 2; c++) begin
      if (ptr_ld[c]) m_ptr[c] = ptr_val[c*8 +: 8];
      else if (rd[c] || wr[c]) m_ptr[c] = m_ptr[c] + (8'd1 << m_st[c]);
      if (stride_ld[c]) m_st[c] = stride_val[c*3 +: 3];
    end
    @(posedge clk);
    @(negedge clk);
    ptr_ld = '0; stride_ld = '0; rd = '0; wr = '0;
    for (int c = 0; c < 2; c++) begin
      chk(tag, int'(ptr[c*8 +: 8]), int'(m_ptr[c]));
      chk(tag, int'(stride[c*3 +: 3]), int'(m_st[c]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 0, 1);
    summary();
  end

  initial begin
    m_ptr[0] = '0; m_ptr[1] = '0; m_st[0] = '0; m_st[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", int'(ptr), 0);
    chk("R1", int'(stride), 0);
    chk("R1", int'(rvalid), 0);

    // R2 R3 loads
    set_ptr(0, 8'h10); set_st(0, 3'd0);
    set_ptr(1, 8'h80); set_st(1, 3'd3);
    step("R2");
    chk("R2", int'(ptr[15:8]), 'h80);
    chk("R3", int'(stride[5:3]), 3);

    // R5 R6 sequential writes at stride 1
    for (int i = 0; i < 4; i++) begin
      do_wr(0, 8'hA0 + 8'(i));
      step("R5");
    end
    chk("R6", int'(ptr[7:0]), 'h14);

    // R8 port 1 writes at stride 8 while port 0 idles, R11 port 0 holds
    for (int i = 0; i < 3; i++) begin
      do_wr(1, 8'h50 + 8'(i));
      step("R11");
    end
    chk("R6", int'(ptr[15:8]), 'h98);

    // R4 read back both streams at once
    set_ptr(0, 8'h10); set_ptr(1, 8'h80);
    step("R2");
    for (int i = 0; i < 3; i++) begin
      do_rd(0); do_rd(1);
      step("R8");
    end
    do_rd(0);
    step("R4");

    // R6 wrap with stride 128 and stride 8
    set_ptr(0, 8'hF0); set_st(0, 3'd7);
    step("R3");
    do_wr(0, 8'h33);
    step("R6");
    chk("R6", int'(ptr[7:0]), 'h70);
    do_wr(0, 8'h44);
    step("R6");
    chk("R6", int'(ptr[7:0]), 'hF0);
    set_ptr(1, 8'hFC);
    step("R2");
    do_rd(1);
    set_st(1, 3'd0);   // same-cycle stride load, old stride 8 applies
    step("R6");
    chk("R6", int'(ptr[15:8]), 'h04);

    // R7 load and access together
    set_ptr(0, 8'h20); set_st(0, 3'd0);
    step("R2");
    do_wr(0, 8'h77); set_ptr(0, 8'h40);
    step("R7");
    chk("R7", int'(ptr[7:0]), 'h40);
    set_ptr(0, 8'h20); do_rd(0);
    step("R7");
    do_rd(0);
    step("R7");

    // R9 both ports write one address
    set_ptr(0, 8'h60); set_ptr(1, 8'h60);
    step("R2");
    do_wr(0, 8'hC0); do_wr(1, 8'hC1);
    step("R9");
    set_ptr(0, 8'h60);
    step("R2");
    do_rd(0);
    step("R9");

    // R10 read against a same-cycle write, cross port and same port
    set_ptr(0, 8'h60); set_ptr(1, 8'h60);
    step("R2");
    do_wr(0, 8'hD5); do_rd(1);
    step("R10");
    set_ptr(1, 8'h60);
    step("R2");
    do_wr(1, 8'hE6); do_rd(1);
    step("R10");
    set_ptr(0, 8'h60);
    step("R2");
    do_rd(0);
    step("R5");

    // R11 idle cycles keep pointers
    step("R11");
    step("R11");
    chk("R4", int'(rvalid), 0);

    repeat (2) @(negedge clk);
    chk("R4", q0.size() + q1.size(), 0);
    summary();
  end
endmodule